// File: doc/BRIEF.md
# Serial Backplane TDM Port

This block connects a chip to an eight-line serial TDM backplane bus. Every line runs at the bus bit clock, 32.768 MHz, and carries 512 byte-wide timeslots in each 125 µs frame. That is 4096 bit periods per line per frame, and the eight lines together reach the full throughput of an H.110 bus. A separate frame-sync line marks the frame boundary. The eight data lines are grouped in fours (lines 0 to 3 and lines 4 to 7) because the two groups reach the backplane through different connector port pairs.

On the chip side there are two memories, each addressed by line*SLOTS+slot. Internal logic writes transmit bytes into the transmit memory. The port shifts each transmit byte out MSB first in its timeslot. The port also assembles each received byte and stores it in the receive memory, where internal logic reads it back through a registered read port.

The port keeps its own bit and timeslot count. Before the first sync it stays silent. After that it keeps counting frames even when no sync arrives. A sync that arrives anywhere other than the expected frame boundary realigns the count at once and sets a sticky resync flag.

Top module: `tdm_backplane_port`

## Requirements
- R1: From reset until the first sync is sampled, every transmit line stays low no matter what the transmit memory holds, and no receive byte is stored.
- R2: A sync sampled high at a rising edge makes the bit period that starts at that edge carry bit 7 of timeslot 0. After that, bit b of timeslot s occupies period 8*s+(7-b) of the frame.
- R3: Each line sends the byte held at transmit address line*SLOTS+slot, most significant bit first, and its value changes only on rising edges.
- R4: Lines 0 to 3 map to bits 0 to 3 of `tx_grp_a` and `rx_grp_a`. Lines 4 to 7 map to bits 0 to 3 of `tx_grp_b` and `rx_grp_b`.
- R5: Receive lines are sampled on the falling edge inside each bit period. Once bit 0 of a timeslot has been sampled, the assembled byte is stored at receive address line*SLOTS+slot, with the first bit received as its MSB. An address on `rx_rd_addr` before a rising edge returns that byte on `rx_rd_data` after that edge.
- R6: A frame is SLOTS*8 bit periods long (4096 at the default). With no sync, the period after bit 0 of timeslot SLOTS-1 is bit 7 of timeslot 0.
- R7: Two kinds of sync leave `resync_flag` low: the first sync after reset, and a sync sampled during bit 0 of timeslot SLOTS-1.
- R8: A sync sampled at any other point in a running frame realigns the count as in R2 and sets `resync_flag`. The flag then stays high until reset.
- R9: Reset clears `resync_flag`, drives the transmit lines low and returns the port to waiting for a sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame sync, one bit period high |
| rx_grp_a | input | 4 | Receive lines 0 to 3 |
| rx_grp_b | input | 4 | Receive lines 4 to 7 |
| tx_grp_a | output | 4 | Transmit lines 0 to 3 |
| tx_grp_b | output | 4 | Transmit lines 4 to 7 |
| tx_wr_en | input | 1 | Transmit memory write strobe |
| tx_wr_addr | input | 12 | Transmit memory address, line*SLOTS+slot |
| tx_wr_data | input | 8 | Byte to be written to the transmit memory |
| rx_rd_addr | input | 12 | Receive memory address, line*SLOTS+slot |
| rx_rd_data | output | 8 | Received byte, one edge after the address |
| resync_flag | output | 1 | Sticky flag for an out-of-place sync |

## Verification
The sync raises no output change until the very edge that samples it. From that edge the lines show bit 7 of timeslot 0 and, when the sync was misplaced, the flag is set. The bench therefore reads the transmit lines and the flag 2 ns after every rising edge, and it counts bit periods from the edge that sampled the sync. Each received byte is written at the edge that ends its bit-0 period. The bench presents the read address during the following bit period and compares `rx_rd_data` one edge later. The bytes of timeslot SLOTS-1 are read back in the first two periods of the next frame. Receive inputs change shortly after the rising edge, so each value is stable when the falling edge samples it.

// File: rtl/tdm_bus_pkg.sv
package tdm_bus_pkg;

    localparam int SLOT_BITS = 8;
    localparam int BIT_W     = $clog2(SLOT_BITS);

    typedef logic [SLOT_BITS-1:0] tdm_byte_t;

    // Frame alignment state: waiting for the first sync, or counting.
    typedef enum logic {
        FR_HUNT   = 1'b0,
        FR_LOCKED = 1'b1
    } frame_state_e;

    // Bit position inside a timeslot; valid is low while hunting.
    typedef struct packed {
        logic             valid;
        logic [BIT_W-1:0] bitno;
    } bit_pos_t;

    localparam logic [BIT_W-1:0] FIRST_BIT = BIT_W'(SLOT_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = '0;

endpackage

// File: rtl/tdm_slot_ram.sv
module tdm_slot_ram
    import tdm_bus_pkg::*;
#(
    parameter int DEPTH      = 512,
    parameter bit ASYNC_READ = 1'b0,
    parameter int AW         = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  tdm_byte_t       wdata,
    input  logic [AW-1:0]   raddr,
    output tdm_byte_t       rdata
);

    tdm_byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        if (ASYNC_READ) begin : g_comb_rd
            assign rdata = mem[raddr];
        end else begin : g_reg_rd
            tdm_byte_t rdata_q;
            always_ff @(posedge clk) begin
                rdata_q <= mem[raddr];
            end
            assign rdata = rdata_q;
        end
    endgenerate

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_bus_pkg::*;
#(
    parameter int SLOTS = 512,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_in,
    output logic [SW-1:0] cur_slot,
    output bit_pos_t      cur_pos,
    output logic [SW-1:0] nxt_slot,
    output bit_pos_t      nxt_pos,
    output logic          resync_flag
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    frame_state_e     state_q;
    logic [BIT_W-1:0] bit_q;
    logic             at_last;

    assign at_last = (cur_slot == LAST_SLOT) && (bit_q == LAST_BIT);

    always_comb begin
        if (sync_in) begin
            nxt_slot      = '0;
            nxt_pos.bitno = FIRST_BIT;
        end else if (bit_q == LAST_BIT) begin
            nxt_slot      = at_last ? '0 : cur_slot + 1'b1;
            nxt_pos.bitno = FIRST_BIT;
        end else begin
            nxt_slot      = cur_slot;
            nxt_pos.bitno = bit_q - 1'b1;
        end
        nxt_pos.valid = sync_in || (state_q == FR_LOCKED);
    end

    assign cur_pos.valid = (state_q == FR_LOCKED);
    assign cur_pos.bitno = bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FR_HUNT;
            cur_slot    <= LAST_SLOT;
            bit_q       <= LAST_BIT;
            resync_flag <= 1'b0;
        end else begin
            if (nxt_pos.valid) begin
                cur_slot <= nxt_slot;
                bit_q    <= nxt_pos.bitno;
            end
            if (sync_in) begin
                state_q <= FR_LOCKED;
                if ((state_q == FR_LOCKED) && !at_last) begin
                    resync_flag <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
    import tdm_bus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bit_pos_t  nxt_pos,
    input  tdm_byte_t byte_in,
    output logic      line_out
);

    logic [SLOT_BITS-2:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst || !nxt_pos.valid) begin
            shift_q  <= '0;
            line_out <= 1'b0;
        end else if (nxt_pos.bitno == FIRST_BIT) begin
            line_out <= byte_in[SLOT_BITS-1];
            shift_q  <= byte_in[SLOT_BITS-2:0];
        end else begin
            line_out <= shift_q[SLOT_BITS-2];
            shift_q  <= {shift_q[SLOT_BITS-3:0], 1'b0};
        end
    end

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
    import tdm_bus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_in,
    input  bit_pos_t  cur_pos,
    output logic      we,
    output tdm_byte_t byte_out
);

    logic                 sample_q;
    logic [SLOT_BITS-2:0] shift_q;

    // Mid-period sample on the falling edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            sample_q <= 1'b0;
        end else begin
            sample_q <= line_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (cur_pos.valid) begin
            shift_q <= {shift_q[SLOT_BITS-3:0], sample_q};
        end
    end

    assign byte_out = {shift_q, sample_q};
    assign we       = cur_pos.valid && (cur_pos.bitno == LAST_BIT);

endmodule

// File: rtl/tdm_backplane_port.sv
module tdm_backplane_port
    import tdm_bus_pkg::*;
#(
    parameter int GROUP_LINES = 4,
    parameter int SLOTS       = 512
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          sync_in,
    input  logic [GROUP_LINES-1:0]                        rx_grp_a,
    input  logic [GROUP_LINES-1:0]                        rx_grp_b,
    output logic [GROUP_LINES-1:0]                        tx_grp_a,
    output logic [GROUP_LINES-1:0]                        tx_grp_b,
    input  logic                                          tx_wr_en,
    input  logic [$clog2(2*GROUP_LINES)+$clog2(SLOTS)-1:0] tx_wr_addr,
    input  logic [SLOT_BITS-1:0]                          tx_wr_data,
    input  logic [$clog2(2*GROUP_LINES)+$clog2(SLOTS)-1:0] rx_rd_addr,
    output logic [SLOT_BITS-1:0]                          rx_rd_data,
    output logic                                          resync_flag
);

    localparam int LINES  = 2 * GROUP_LINES;
    localparam int SW     = $clog2(SLOTS);
    localparam int LW     = $clog2(LINES);
    localparam int ADDR_W = LW + SW;

    logic [LINES-1:0] rx_line;
    logic [LINES-1:0] tx_line;
    logic [LINES-1:0] rx_we;
    logic [SW-1:0]    cur_slot;
    logic [SW-1:0]    nxt_slot;
    bit_pos_t         cur_pos;
    bit_pos_t         nxt_pos;
    logic [LW-1:0]    wr_line;
    logic [SW-1:0]    wr_slot;
    logic [LW-1:0]    rd_line_q;
    tdm_byte_t        bank_q [LINES];

    assign rx_line  = {rx_grp_b, rx_grp_a};
    assign tx_grp_a = tx_line[GROUP_LINES-1:0];
    assign tx_grp_b = tx_line[LINES-1:GROUP_LINES];

    assign wr_line = tx_wr_addr[ADDR_W-1 -: LW];
    assign wr_slot = tx_wr_addr[SW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_line_q <= '0;
        end else begin
            rd_line_q <= rx_rd_addr[ADDR_W-1 -: LW];
        end
    end

    assign rx_rd_data = bank_q[rd_line_q];

    tdm_frame_timer #(
        .SLOTS (SLOTS)
    ) timer_i (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .cur_slot    (cur_slot),
        .cur_pos     (cur_pos),
        .nxt_slot    (nxt_slot),
        .nxt_pos     (nxt_pos),
        .resync_flag (resync_flag)
    );

    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            tdm_byte_t tx_byte;
            tdm_byte_t rx_byte;
            logic      tx_we;

            assign tx_we = tx_wr_en && (wr_line == LW'(l));

            tdm_slot_ram #(
                .DEPTH      (SLOTS),
                .ASYNC_READ (1'b1)
            ) tx_ram_i (
                .clk   (clk),
                .we    (tx_we),
                .waddr (wr_slot),
                .wdata (tx_wr_data),
                .raddr (nxt_slot),
                .rdata (tx_byte)
            );

            tdm_tx_lane tx_lane_i (
                .clk      (clk),
                .rst      (rst),
                .nxt_pos  (nxt_pos),
                .byte_in  (tx_byte),
                .line_out (tx_line[l])
            );

            tdm_rx_lane rx_lane_i (
                .clk      (clk),
                .rst      (rst),
                .line_in  (rx_line[l]),
                .cur_pos  (cur_pos),
                .we       (rx_we[l]),
                .byte_out (rx_byte)
            );

            tdm_slot_ram #(
                .DEPTH      (SLOTS),
                .ASYNC_READ (1'b0)
            ) rx_ram_i (
                .clk   (clk),
                .we    (rx_we[l]),
                .waddr (cur_slot),
                .wdata (rx_byte),
                .raddr (rx_rd_addr[SW-1:0]),
                .rdata (bank_q[l])
            );
        end
    endgenerate

endmodule

// File: rtl/tdm_backplane_port_chk.sv
module tdm_backplane_port_chk
    import tdm_bus_pkg::*;
#(
    parameter int LINES = 8,
    parameter int SLOTS = 512,
    parameter int SW    = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_in,
    input logic [LINES-1:0] tx_lines,
    input logic [SW-1:0]    cur_slot,
    input bit_pos_t         cur_pos,
    input logic             resync_flag,
    input logic [LINES-1:0] rx_we
);

    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cur_pos.valid |-> (tx_lines == '0 && rx_we == '0)); // R1

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (cur_pos.valid && cur_slot == '0 && cur_pos.bitno == FIRST_BIT)); // R2

    AST_RX_STORE_AT_BYTE_END: assert property (@(posedge clk) disable iff (rst)
        (rx_we != '0) |-> (cur_pos.valid && cur_pos.bitno == LAST_BIT && $countones(rx_we) == LINES)); // R5

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cur_pos.valid && !sync_in && cur_slot == LAST_SLOT && cur_pos.bitno == LAST_BIT)
        |=> (cur_slot == '0 && cur_pos.bitno == FIRST_BIT)); // R6

    AST_BOUNDARY_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sync_in && !resync_flag && (!cur_pos.valid || (cur_slot == LAST_SLOT && cur_pos.bitno == LAST_BIT)))
        |=> !resync_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        resync_flag |=> resync_flag); // R8

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(resync_flag) |-> $past(sync_in)); // R8

endmodule

bind tdm_backplane_port tdm_backplane_port_chk #(
    .LINES (LINES),
    .SLOTS (SLOTS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sync_in     (sync_in),
    .tx_lines    (tx_line),
    .cur_slot    (cur_slot),
    .cur_pos     (cur_pos),
    .resync_flag (resync_flag),
    .rx_we       (rx_we)
);

// File: tb/tdm_backplane_port_tb_top.sv
module tdm_backplane_port_tb_top;

    localparam int GL    = 4;
    localparam int LINES = 8;
    localparam int SLOTS = 512;
    localparam int AW    = 12;
    localparam int FRAME = SLOTS * 8;
    localparam int NVEC  = 8;

    // {line, slot, byte}: transmit byte and receive readback address.
    localparam logic [19:0] VEC [NVEC] = '{
        {3'd0, 9'd0,   8'hA5},
        {3'd1, 9'd1,   8'h3C},
        {3'd2, 9'd17,  8'h81},
        {3'd3, 9'd100, 8'hFF},
        {3'd4, 9'd255, 8'h01},
        {3'd5, 9'd300, 8'h7E},
        {3'd6, 9'd510, 8'hC3},
        {3'd7, 9'd511, 8'h96}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_in = 1'b0;
    logic [GL-1:0] rx_a = '0;
    logic [GL-1:0] rx_b = '0;
    logic [GL-1:0] tx_a;
    logic [GL-1:0] tx_b;
    logic          tx_wr_en = 1'b0;
    logic [AW-1:0] tx_wr_addr = '0;
    logic [7:0]    tx_wr_data = '0;
    logic [AW-1:0] rx_rd_addr = '0;
    logic [7:0]    rx_rd_data;
    logic          resync_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tdm_backplane_port #(
        .GROUP_LINES (GL),
        .SLOTS       (SLOTS)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .rx_grp_a    (rx_a),
        .rx_grp_b    (rx_b),
        .tx_grp_a    (tx_a),
        .tx_grp_b    (tx_b),
        .tx_wr_en    (tx_wr_en),
        .tx_wr_addr  (tx_wr_addr),
        .tx_wr_data  (tx_wr_data),
        .rx_rd_addr  (rx_rd_addr),
        .rx_rd_data  (rx_rd_data),
        .resync_flag (resync_flag)
    );

    function automatic int vline(int i);
        return int'(VEC[i][19:17]);
    endfunction

    function automatic int vslot(int i);
        return int'(VEC[i][16:8]);
    endfunction

    function automatic logic [7:0] vbyte(int i);
        return VEC[i][7:0];
    endfunction

    function automatic logic [7:0] rx_pat(int l, int s, int seed);
        return 8'((s * 13 + l * 41 + seed * 97 + 90) ^ (s >> 1));
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic drive_period(int s, int b, int seed);
        logic [LINES-1:0] v;
        for (int l = 0; l < LINES; l++) begin
            logic [7:0] pat;
            pat  = rx_pat(l, s, seed);
            v[l] = pat[b];
        end
        {rx_b, rx_a} = v;
    endtask

    // One frame from period 0; optional sync in the last period or at 'cut'.
    task automatic run_frame(int seed, bit sync_end, int cut, bit exp_flag, int prev_seed);
        logic [7:0] obs [LINES];
        int rd_idx;
        int rd_seed;
        bit rd_pending;
        rd_pending = 1'b0;
        rd_idx     = 0;
        rd_seed    = 0;
        for (int l = 0; l < LINES; l++) obs[l] = '0;
        for (int p = 0; p < FRAME; p++) begin
            int s;
            int b;
            logic [LINES-1:0] txv;
            @(posedge clk);
            #2;
            s = p / 8;
            b = 7 - (p % 8);
            drive_period(s, b, seed);
            sync_in = (sync_end && p == FRAME - 1) || (p == cut);
            txv = {tx_b, tx_a};
            for (int l = 0; l < LINES; l++) obs[l] = {obs[l][6:0], txv[l]};
            if (p == 0) begin
                if (exp_flag) check("R8 resync flag after misplaced sync", int'(resync_flag), 1);
                else          check("R7 resync flag after aligned sync", int'(resync_flag), 0);
            end
            if (b == 0) begin
                for (int i = 0; i < NVEC; i++) begin
                    if (vslot(i) == s) check("R2 R3 R4 transmitted byte", int'(obs[vline(i)]), int'(vbyte(i)));
                end
            end
            if (p % 8 == 1 && rd_pending) begin
                check("R5 received byte readback", int'(rx_rd_data),
                      int'(rx_pat(vline(rd_idx), vslot(rd_idx), rd_seed)));
                rd_pending = 1'b0;
            end
            if (p % 8 == 0) begin
                for (int i = 0; i < NVEC; i++) begin
                    if ((p > 0 && vslot(i) == s - 1) ||
                        (p == 0 && prev_seed >= 0 && vslot(i) == SLOTS - 1)) begin
                        rx_rd_addr = AW'(vline(i) * SLOTS + vslot(i));
                        rd_idx     = i;
                        rd_seed    = (p == 0) ? prev_seed : seed;
                        rd_pending = 1'b1;
                    end
                end
            end
            if (p == cut) break;
        end
    endtask

    task automatic lock_now();
        @(posedge clk);
        #2;
        {rx_b, rx_a} = '0;
        sync_in = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 transmit lines in reset", int'({tx_b, tx_a}), 0);
        check("R9 resync flag in reset", int'(resync_flag), 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            #2;
            tx_wr_en   = 1'b1;
            tx_wr_addr = AW'(vline(i) * SLOTS + vslot(i));
            tx_wr_data = vbyte(i);
        end
        @(posedge clk);
        #2;
        tx_wr_en = 1'b0;

        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            #2;
            check("R1 lines idle before first sync", int'({tx_b, tx_a}), 0);
        end

        lock_now();
        run_frame(1, 1'b1, -1, 1'b0, -1);
        run_frame(2, 1'b0, -1, 1'b0, 1);
        run_frame(3, 1'b0, 1000, 1'b0, 2);   // R6 frame entered by wrap, then misplaced sync
        run_frame(4, 1'b1, -1, 1'b1, -1);
        run_frame(5, 1'b0, -1, 1'b1, 4);

        @(posedge clk);
        #2;
        sync_in = 1'b0;
        rst     = 1'b1;
        @(posedge clk);
        #2;
        check("R9 resync flag cleared by reset", int'(resync_flag), 0);
        check("R9 lines low after reset", int'({tx_b, tx_a}), 0);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #2;
            check("R9 lines idle until new sync", int'({tx_b, tx_a}), 0);
        end

        lock_now();
        run_frame(6, 1'b0, -1, 1'b0, -1);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

endmodule